// File: doc/BRIEF.md
# Embedded Sync Inserter for Dual-Stream 10-bit 4:2:2 Video

This block takes 10-bit 4:2:2 video that is framed by separate line-valid and frame-valid strobes and turns it into two parallel 10-bit streams, luma and chroma, with the timing carried inside the data. Each line is opened by a start-of-video timing reference and closed by an end-of-video timing reference. A timing reference is a three-word preamble followed by a status word. Each stream carries its own copy of every reference and of every blanking word. The chroma stream keeps the Cb/Cr alternation of its input, and the luma stream runs at one sample per clock.

The block follows the input's own line timing. Every input sample comes out a fixed six cycles later. The four cycles before a line's first sample are overwritten with the start reference, and the four cycles after its last sample are overwritten with the end reference. A line that arrives while frame-valid is low is sent as a vertical blanking line: it gets the blanking variant of both references, and its sample positions are filled with blanking levels. Active samples are clipped to the legal range, so the words reserved for the references never appear inside active video. The horizontal blanking that remains between references is the input gap minus eight cycles.

The input must follow three rules. Line-valid must stay low for at least eight cycles between lines. After reset, at least four idle cycles must pass before the first line. Frame-valid must stay constant for the whole of a line.

Top module: `emb_sync_inserter`

## Requirements
- R1: While `rst` is high, and in the cycles after it until a line reaches the output, `y_out` is 0x040 and `c_out` is 0x200, whatever the inputs carry.
- R2: A sample presented with `lv_in` and `fv_in` both high, and lying inside the legal range, appears on `y_out`/`c_out` exactly six clock cycles later. Samples leave in the order they arrived, so the Cb/Cr order on the chroma stream is preserved.
- R3: Active samples on either stream are clipped to 4..1019: a value below 4 comes out as 4 and a value above 1019 comes out as 1019.
- R4: The four output cycles just before the first sample slot of a line carry 0x3FF, 0x000, 0x000 and then the status word, identically on both streams.
- R5: The four output cycles just after the last sample slot of a line carry 0x3FF, 0x000, 0x000 and then the status word, identically on both streams.
- R6: The status word is {1, F, V, H, V^H, F^H, F^V, F^V^H, 0, 0}, written from bit 9 down to bit 0. F is always 0. V is 1 on a vertical blanking line. H is 0 for the start reference and 1 for the end reference. This gives 0x200 and 0x274 on active lines, and 0x2AC and 0x2D8 on vertical blanking lines.
- R7: A line presented with `lv_in` high while `fv_in` is low uses the V=1 status words, and every one of its sample slots carries 0x040 on luma and 0x200 on chroma.
- R8: Every output cycle that is neither a sample slot nor a timing reference word carries 0x040 on luma and 0x200 on chroma.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fv_in | input | 1 | Frame valid; low marks vertical blanking lines |
| lv_in | input | 1 | Line valid; high for each sample of a line |
| y_in | input | 10 | Luma sample |
| c_in | input | 10 | Chroma sample, alternating Cb and Cr |
| y_out | output | 10 | Luma stream with embedded timing references |
| c_out | output | 10 | Chroma stream with embedded timing references |

## Verification
The assertions check on every cycle the properties that can be judged locally:
- 0x3FF is always followed by two zero words and then a well-formed status word with consistent protection bits.
- Both streams carry the same reference words.
- The reserved values 1..3 and 1020..1022 never appear on either stream.
- Legal active samples arrive six cycles after they enter.
- Sample slots of vertical blanking lines carry blanking levels.

Only the scenario-driven scoreboard can show the rest:
- Each reference sits exactly next to the first or last sample of its line.
- The right one of the four status values is picked.
- Clipping works at both ends of the range.
- Lines of width one and minimum eight-cycle gaps are framed correctly.

// File: rtl/emb_sync_pkg.sv
package emb_sync_pkg;
  localparam int unsigned SW = 10;
  localparam logic [SW-1:0] PRE_ONES  = 10'h3FF;
  localparam logic [SW-1:0] PRE_ZERO  = 10'h000;
  localparam logic [SW-1:0] BLANK_Y   = 10'h040;
  localparam logic [SW-1:0] BLANK_C   = 10'h200;

  typedef enum logic [2:0] {
    K_BLANK,
    K_ACTIVE,
    K_ONES,
    K_ZERO,
    K_STATUS
  } word_kind_e;

  // Status word: marker, field, vertical, horizontal, four protection bits, two zeros
  function automatic logic [SW-1:0] status_word(input logic f, input logic v, input logic h);
    status_word = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction
endpackage

// File: rtl/ess_delay_line.sv
module ess_delay_line #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
    end else begin
      stage[0] <= din;
      for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
    end
  end

  assign dout = stage[DEPTH-1];
endmodule

// File: rtl/ess_clip.sv
module ess_clip #(
  parameter int unsigned W  = 10,
  parameter int unsigned LO = 4,
  parameter int unsigned HI = 1019
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);

  always_comb begin
    if (din < LO_V)      dout = LO_V;
    else if (din > HI_V) dout = HI_V;
    else                 dout = din;
  end
endmodule

// File: rtl/emb_sync_inserter.sv
module emb_sync_inserter
  import emb_sync_pkg::*;
#(
  parameter int unsigned CLIP_LO = 4,
  parameter int unsigned CLIP_HI = 1019
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fv_in,
  input  logic          lv_in,
  input  logic [SW-1:0] y_in,
  input  logic [SW-1:0] c_in,
  output logic [SW-1:0] y_out,
  output logic [SW-1:0] c_out
);
  localparam int unsigned TRS_LEN   = 4;              // words per timing reference
  localparam int unsigned CENTER    = TRS_LEN;        // tap aligned with the output slot
  localparam int unsigned FLAG_TAPS = 2 * TRS_LEN + 1;
  localparam int unsigned DATA_DEP  = CENTER + 1;

  // Strobe history: one single-stage delay per tap so every tap is visible
  logic [1:0]           flag_tap [FLAG_TAPS];
  logic [FLAG_TAPS-1:0] lv_t, fv_t;

  for (genvar k = 0; k < FLAG_TAPS; k++) begin : g_flag
    if (k == 0) begin : g_head
      ess_delay_line #(.W(2), .DEPTH(1)) u_tap (
        .clk(clk), .rst(rst), .din({fv_in, lv_in}), .dout(flag_tap[k]));
    end else begin : g_body
      ess_delay_line #(.W(2), .DEPTH(1)) u_tap (
        .clk(clk), .rst(rst), .din(flag_tap[k-1]), .dout(flag_tap[k]));
    end
    assign lv_t[k] = flag_tap[k][0];
    assign fv_t[k] = flag_tap[k][1];
  end

  // Sample data only needs the tap that lines up with the output slot
  logic [SW-1:0] y_d, c_d;
  ess_delay_line #(.W(2*SW), .DEPTH(DATA_DEP)) u_data (
    .clk(clk), .rst(rst), .din({c_in, y_in}), .dout({c_d, y_d}));

  logic [SW-1:0] raw_s  [2];
  logic [SW-1:0] clip_s [2];
  assign raw_s[0] = y_d;
  assign raw_s[1] = c_d;

  for (genvar g = 0; g < 2; g++) begin : g_clip
    ess_clip #(.W(SW), .LO(CLIP_LO), .HI(CLIP_HI)) u_clip (
      .din(raw_s[g]), .dout(clip_s[g]));
  end

  // Classify the word in the output slot from the strobe history around it
  word_kind_e kind;
  logic       st_v, st_h;

  always_comb begin
    kind = K_BLANK;
    st_v = 1'b0;
    st_h = 1'b0;
    if (lv_t[CENTER]) begin
      kind = fv_t[CENTER] ? K_ACTIVE : K_BLANK;
    end else begin
      // Start reference: a line begins within the next TRS_LEN slots
      for (int k = 0; k < TRS_LEN; k++) begin
        if (lv_t[k] && !lv_t[k+1]) begin
          if (k == 0)                 kind = K_ONES;
          else if (k == TRS_LEN - 1)  begin kind = K_STATUS; st_v = !fv_t[k]; st_h = 1'b0; end
          else                        kind = K_ZERO;
        end
      end
      // End reference: a line finished within the last TRS_LEN slots
      for (int m = 1; m <= TRS_LEN; m++) begin
        if (lv_t[CENTER+m] && !lv_t[CENTER+m-1]) begin
          if (m == 1)                 kind = K_ONES;
          else if (m == TRS_LEN)      begin kind = K_STATUS; st_v = !fv_t[CENTER+m]; st_h = 1'b1; end
          else                        kind = K_ZERO;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_out <= BLANK_Y;
      c_out <= BLANK_C;
    end else begin
      unique case (kind)
        K_ACTIVE: begin y_out <= clip_s[0]; c_out <= clip_s[1]; end
        K_ONES:   begin y_out <= PRE_ONES;  c_out <= PRE_ONES;  end
        K_ZERO:   begin y_out <= PRE_ZERO;  c_out <= PRE_ZERO;  end
        K_STATUS: begin
          y_out <= status_word(1'b0, st_v, st_h);
          c_out <= status_word(1'b0, st_v, st_h);
        end
        default:  begin y_out <= BLANK_Y;   c_out <= BLANK_C;   end
      endcase
    end
  end
endmodule

// File: rtl/emb_sync_inserter_chk.sv
module emb_sync_inserter_chk (
  input logic       clk,
  input logic       rst,
  input logic       fv_in,
  input logic       lv_in,
  input logic [9:0] y_in,
  input logic [9:0] c_in,
  input logic [9:0] y_out,
  input logic [9:0] c_out
);
  logic [3:0] cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 4'd15) cyc <= cyc + 4'd1;
  end

  assert_reset_blank_R1: assert property (@(posedge clk)
    $past(rst) |-> (y_out == 10'h040 && c_out == 10'h200));

  // R4 and R5 share the preamble shape
  assert_preamble_order_R4: assert property (@(posedge clk) disable iff (rst)
    (y_out == 10'h3FF) |=> (y_out == 10'h000) ##1 (y_out == 10'h000)
                           ##1 (y_out[9] && y_out[1:0] == 2'b00));

  assert_streams_share_codes_R5: assert property (@(posedge clk) disable iff (rst)
    (y_out == 10'h3FF || y_out == 10'h000) |-> (c_out == y_out));

  assert_status_protect_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(y_out, 3) == 10'h3FF && $past(y_out, 2) == 10'h000 && $past(y_out, 1) == 10'h000)
    |-> (y_out[8] == 1'b0 &&
         y_out[5:2] == {y_out[7] ^ y_out[6], y_out[8] ^ y_out[6],
                        y_out[8] ^ y_out[7], y_out[8] ^ y_out[7] ^ y_out[6]}));

  assert_legal_range_R3: assert property (@(posedge clk) disable iff (rst)
    !((y_out >= 10'd1 && y_out <= 10'd3) || (y_out >= 10'd1020 && y_out <= 10'd1022) ||
      (c_out >= 10'd1 && c_out <= 10'd3) || (c_out >= 10'd1020 && c_out <= 10'd1022)));

  assert_active_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 4'd8 && $past(lv_in, 6) && $past(fv_in, 6) &&
     $past(y_in, 6) >= 10'd4 && $past(y_in, 6) <= 10'd1019 &&
     $past(c_in, 6) >= 10'd4 && $past(c_in, 6) <= 10'd1019)
    |-> (y_out == $past(y_in, 6) && c_out == $past(c_in, 6)));

  assert_vblank_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 4'd8 && $past(lv_in, 6) && !$past(fv_in, 6))
    |-> (y_out == 10'h040 && c_out == 10'h200));
endmodule

bind emb_sync_inserter emb_sync_inserter_chk u_chk (
  .clk(clk), .rst(rst), .fv_in(fv_in), .lv_in(lv_in),
  .y_in(y_in), .c_in(c_in), .y_out(y_out), .c_out(c_out));

// File: tb/tb_emb_sync_inserter.sv
`timescale 1ns/1ps
module tb_emb_sync_inserter;
  localparam int LAT  = 6;
  localparam int MAXN = 512;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fv_in = 1'b0, lv_in = 1'b0;
  logic [9:0] y_in = '0, c_in = '0;
  logic [9:0] y_out, c_out;

  always #2 clk = ~clk;  // 250 MHz

  emb_sync_inserter dut (
    .clk(clk), .rst(rst), .fv_in(fv_in), .lv_in(lv_in),
    .y_in(y_in), .c_in(c_in), .y_out(y_out), .c_out(c_out));

  bit         s_lv [MAXN];
  bit         s_fv [MAXN];
  logic [9:0] s_y  [MAXN];
  logic [9:0] s_c  [MAXN];
  int         len = 0;

  int  n_checks = 0, n_fail = 0;
  bit  finished = 0, mon_go = 0, mon_done = 0;
  logic [9:0] qy [$];
  logic [9:0] qc [$];
  string      qt [$];

  function automatic logic [9:0] edge_val(int k);
    case (k % 9)
      0: return 10'd0;    1: return 10'd1;    2: return 10'd3;
      3: return 10'd4;    4: return 10'd5;    5: return 10'd1018;
      6: return 10'd1019; 7: return 10'd1020; default: return 10'd1023;
    endcase
  endfunction

  function automatic logic [9:0] legal(logic [9:0] v);
    if (v < 10'd4) return 10'd4;
    if (v > 10'd1019) return 10'd1019;
    return v;
  endfunction

  task automatic add_idle(int n, bit fv);
    for (int i = 0; i < n; i++) begin
      s_lv[len] = 0; s_fv[len] = fv; s_y[len] = '0; s_c[len] = '0; len++;
    end
  endtask

  task automatic add_line(bit fv, int w, int seed, bit edgy);
    for (int i = 0; i < w; i++) begin
      s_lv[len] = 1; s_fv[len] = fv;
      if (edgy) begin
        s_y[len] = edge_val(i);
        s_c[len] = edge_val(i + 4);
      end else begin
        s_y[len] = 10'((i * 97 + seed * 31) % 1024);
        s_c[len] = 10'(((i % 2) ? 600 : 400) + ((i * 13 + seed) % 90));  // Cr / Cb alternation
      end
      len++;
    end
  endtask

  function automatic bit lv_at(int t);
    return (t >= 0 && t < len) ? s_lv[t] : 1'b0;
  endfunction

  // Independent model of the output slot that belongs to input index t
  task automatic expect_at(int t, output logic [9:0] ey, output logic [9:0] ec, output string tg);
    int fwd, back;
    ey = 10'h040; ec = 10'h200; tg = "R8 horizontal blanking";
    if (s_lv[t]) begin
      if (s_fv[t]) begin
        ey = legal(s_y[t]); ec = legal(s_c[t]);
        tg = (ey != s_y[t] || ec != s_c[t]) ? "R3 clipped sample" : "R2 active sample";
      end else begin
        tg = "R7 vblank slot";
      end
      return;
    end
    fwd = 0; back = 0;
    for (int d = 1; d <= 4; d++) if (fwd == 0 && lv_at(t + d)) fwd = d;
    for (int m = 1; m <= 4; m++) if (back == 0 && lv_at(t - m)) back = m;
    if (fwd != 0) begin
      tg = "R4 start preamble";
      if (fwd == 4) begin ey = 10'h3FF; ec = 10'h3FF; end
      else if (fwd > 1) begin ey = 10'h000; ec = 10'h000; end
      else begin
        ey = s_fv[t+1] ? 10'h200 : 10'h2AC; ec = ey;
        tg = s_fv[t+1] ? "R6 start status" : "R7 vblank start status";
      end
    end else if (back != 0) begin
      tg = "R5 end preamble";
      if (back == 1) begin ey = 10'h3FF; ec = 10'h3FF; end
      else if (back < 4) begin ey = 10'h000; ec = 10'h000; end
      else begin
        ey = s_fv[t-4] ? 10'h274 : 10'h2D8; ec = ey;
        tg = s_fv[t-4] ? "R6 end status" : "R7 vblank end status";
      end
    end
  endtask

  task automatic check(string tg, logic [9:0] ey, logic [9:0] ec);
    n_checks++;
    if (y_out !== ey || c_out !== ec) begin
      n_fail++;
      $display("FAIL %s: y_out=%h c_out=%h expected y=%h c=%h", tg, y_out, c_out, ey, ec);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Driver: pushes the expected word for each index as it drives it
  task automatic drive_stream();
    logic [9:0] ey, ec;
    string tg;
    for (int n = 0; n < len + LAT; n++) begin
      @(negedge clk);
      if (n < len) begin
        expect_at(n, ey, ec, tg);
        qy.push_back(ey); qc.push_back(ec); qt.push_back(tg);
        lv_in = s_lv[n]; fv_in = s_fv[n]; y_in = s_y[n]; c_in = s_c[n];
      end else begin
        lv_in = 0; fv_in = 0; y_in = '0; c_in = '0;
      end
    end
  endtask

  // Monitor: pops and compares once the pipeline has filled
  initial begin
    wait (mon_go);
    for (int k = 0; k < len + LAT; k++) begin
      @(negedge clk);
      if (k >= LAT && qy.size() > 0) check(qt.pop_front(), qy.pop_front(), qc.pop_front());
    end
    mon_done = 1;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run incomplete, expected completion");
      finish_run();
    end
  end

  initial begin
    // Frame: leading idle, two vblank lines, active lines incl. edge values and width 1, trailing vblank
    add_idle(10, 0);
    add_line(0, 12, 1, 0);  add_idle(10, 0);
    add_line(0, 6, 2, 0);   add_idle(9, 1);
    add_line(1, 16, 3, 0);  add_idle(8, 1);
    add_line(1, 18, 4, 1);  add_idle(12, 1);
    add_line(1, 9, 5, 0);   add_idle(8, 1);
    add_line(1, 1, 6, 0);   add_idle(10, 0);
    add_line(0, 5, 7, 0);   add_idle(12, 0);

    // R1: outputs stay blank while reset holds, even with busy inputs
    lv_in = 1; fv_in = 1; y_in = 10'h3FF; c_in = 10'h3FF;
    repeat (5) @(negedge clk);
    check("R1 during reset", 10'h040, 10'h200);
    lv_in = 0; fv_in = 0; y_in = '0; c_in = '0;
    rst = 0;
    repeat (2) begin
      @(negedge clk);
      check("R1 after reset", 10'h040, 10'h200);
    end
    #1 mon_go = 1;
    drive_stream();
    wait (mon_done);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule